// File: doc/BRIEF.md
# Two-Level Block-Transfer DMA Channel

This block is one DMA channel that copies a block of 64-bit words from a source region to a destination. The block is split into two nested counts: a number of elements in each frame, and a number of frames. Each element is a 64-bit read on the master bus followed by a 64-bit write of the same word. The usual use is to stream a memory region into one fixed destination address, for example a signature-compression register. To do that, the source address steps forward by 8 bytes and the destination address stays fixed.

Software loads a small set of registers and then writes a trigger. The whole element-by-frame block then runs with no further requests. The frame count field is 13 bits wide, so a large region must be split across both counts. A one-cycle completion pulse marks the end of each block. An optional re-arm setting reloads the programmed set and starts the block again. A global enable gates every transfer, and clearing it abandons a transfer in progress.

Top module: `dma_blk_top`

## Requirements
- R1: After a synchronous reset, the outputs `busy`, `bus_req` and `done_irq` are low, and all configuration fields and the global enable are zero.
- R2: Configuration writes use `cfg_addr` as follows: 0 is the source address, 1 is the destination address, 2 is the element count (bits 15:0), 3 is the frame count, 4 is the mode (bit0 = source increments, bit1 = destination increments, bit2 = re-arm), 5 is the global enable (bit0), and a write to 6 is the trigger. A trigger that is accepted raises `busy` in the next cycle and issues a read at the source address.
- R3: Each element is a read (`bus_wr`=0) at the current source address. When the read is acknowledged, the returned 64-bit word is written (`bus_wr`=1) to the current destination address. An unacknowledged request keeps its address and direction unchanged.
- R4: After each write is accepted, the source address advances by 8 bytes if mode bit0 was set at the trigger, and otherwise stays the same. The destination address follows mode bit1 in the same way.
- R5: A block moves exactly element count × frame count elements. The frame count field keeps only bits 12:0 of the written value (largest value 0x1FFF).
- R6: When the last write of a block is accepted and re-arm is off, `done_irq` is high for exactly the next cycle and `busy` drops in that same cycle.
- R7: When re-arm is set at completion, `done_irq` still pulses. The channel then reloads the programmed addresses and counts and starts the next block without a new trigger, and `busy` stays high.
- R8: A trigger is ignored when the element count or the frame count is zero.
- R9: A trigger is ignored while the global enable is clear. Clearing the enable during a transfer drops `busy` one cycle after the enable register changes, with no `done_irq`.
- R10: A trigger that arrives while `busy` is high is ignored and does not restart the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | output | 1 | Master bus request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Master bus byte address |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Request accepted this cycle |
| busy | output | 1 | Block in progress |
| done_irq | output | 1 | One-cycle block-complete pulse |

## Verification
The assertions check four things on every cycle. A request that is not acknowledged holds its address and direction. A completion pulse only ever follows an accepted write. `busy` falls only through completion or a dropped enable. The channel only starts from a trigger with non-zero counts. The bench's scenarios are needed for everything else: the exact element totals for several element and frame splits, truncation of the frame count, address stepping under each mode combination, back-to-back blocks under re-arm, and triggers that must be ignored, each under varied acknowledge latency.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned BEAT_W     = 64;
    localparam int unsigned ELEM_W     = 16;
    localparam int unsigned FRAME_W    = 13;
    localparam int unsigned CFG_AW     = 3;
    localparam int unsigned CFG_DW     = 32;
    localparam int unsigned BEAT_BYTES = BEAT_W / 8;

    localparam logic [CFG_AW-1:0] SEL_SRC    = 3'd0;
    localparam logic [CFG_AW-1:0] SEL_DST    = 3'd1;
    localparam logic [CFG_AW-1:0] SEL_ELEM   = 3'd2;
    localparam logic [CFG_AW-1:0] SEL_FRAME  = 3'd3;
    localparam logic [CFG_AW-1:0] SEL_MODE   = 3'd4;
    localparam logic [CFG_AW-1:0] SEL_GLOBAL = 3'd5;
    localparam logic [CFG_AW-1:0] SEL_KICK   = 3'd6;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  src;
        logic [ADDR_W-1:0]  dst;
        logic [ELEM_W-1:0]  elems;
        logic [FRAME_W-1:0] frames;
        logic               src_inc;
        logic               dst_inc;
        logic               rearm;
    } packet_t;

    function automatic logic packet_ok(packet_t p);
        return (p.elems != '0) && (p.frames != '0);
    endfunction
endpackage

// File: rtl/dma_blk_cfg.sv
module dma_blk_cfg
    import dma_blk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_sel,
    input  logic [CFG_DW-1:0] wr_data,
    output packet_t           pkt,
    output logic              enable,
    output logic              kick
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pkt    <= '0;
            enable <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_SRC:    pkt.src    <= wr_data[ADDR_W-1:0];
                SEL_DST:    pkt.dst    <= wr_data[ADDR_W-1:0];
                SEL_ELEM:   pkt.elems  <= wr_data[ELEM_W-1:0];
                SEL_FRAME:  pkt.frames <= wr_data[FRAME_W-1:0];
                SEL_MODE: begin
                    pkt.src_inc <= wr_data[0];
                    pkt.dst_inc <= wr_data[1];
                    pkt.rearm   <= wr_data[2];
                end
                SEL_GLOBAL: enable <= wr_data[0];
                default: ;
            endcase
        end
    end

    assign kick = wr_en && (wr_sel == SEL_KICK);
endmodule

// File: rtl/dma_blk_loop.sv
module dma_blk_loop #(
    parameter int unsigned EW = 16,
    parameter int unsigned FW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [EW-1:0] elems_init,
    input  logic [FW-1:0] frames_init,
    output logic          last
);
    logic [EW-1:0] elem_left, elem_span;
    logic [FW-1:0] frame_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            elem_left  <= '0;
            elem_span  <= '0;
            frame_left <= '0;
        end else if (load) begin
            elem_left  <= elems_init;
            elem_span  <= elems_init;
            frame_left <= frames_init;
        end else if (step) begin
            if (elem_left == EW'(1)) begin
                elem_left  <= elem_span;
                frame_left <= frame_left - FW'(1);
            end else begin
                elem_left <= elem_left - EW'(1);
            end
        end
    end

    assign last = (elem_left == EW'(1)) && (frame_left == FW'(1));

    // R8: a load only ever happens with both counts non-zero
    assert_count_live_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (elem_left != '0) && (frame_left != '0));
endmodule

// File: rtl/dma_blk_addr.sv
module dma_blk_addr #(
    parameter int unsigned AW   = 32,
    parameter int unsigned STEP = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic          src_inc,
    input  logic          dst_inc,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst
);
    logic src_inc_q, dst_inc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src       <= '0;
            dst       <= '0;
            src_inc_q <= 1'b0;
            dst_inc_q <= 1'b0;
        end else if (load) begin
            src       <= src_init;
            dst       <= dst_init;
            src_inc_q <= src_inc;
            dst_inc_q <= dst_inc;
        end else if (step) begin
            if (src_inc_q) src <= src + AW'(STEP);
            if (dst_inc_q) dst <= dst + AW'(STEP);
        end
    end

    assert_fixed_dst_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !dst_inc_q) |=> $stable(dst));
    assert_fixed_src_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !src_inc_q) |=> $stable(src));
endmodule

// File: rtl/dma_blk_top.sv
module dma_blk_top
    import dma_blk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BEAT_W-1:0] bus_wdata,
    input  logic [BEAT_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              busy,
    output logic              done_irq
);
    packet_t            pkt;
    logic               enable, kick, last;
    logic               start, finish, rearm, load, step;
    logic [ADDR_W-1:0]  cur_src, cur_dst;
    logic [BEAT_W-1:0]  beat_q;
    phase_e             phase_q;

    dma_blk_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_addr),
        .wr_data(cfg_wdata), .pkt(pkt), .enable(enable), .kick(kick)
    );

    assign start  = kick && enable && (phase_q == PH_IDLE) && packet_ok(pkt);
    assign step   = enable && (phase_q == PH_WRITE) && bus_ack;
    assign finish = step && last;
    assign rearm  = finish && pkt.rearm && packet_ok(pkt);
    assign load   = start || rearm;

    dma_blk_loop #(.EW(ELEM_W), .FW(FRAME_W)) u_loop (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .elems_init(pkt.elems), .frames_init(pkt.frames), .last(last)
    );

    dma_blk_addr #(.AW(ADDR_W), .STEP(BEAT_BYTES)) u_addr (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .src_init(pkt.src), .dst_init(pkt.dst),
        .src_inc(pkt.src_inc), .dst_inc(pkt.dst_inc),
        .src(cur_src), .dst(cur_dst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            beat_q   <= '0;
            done_irq <= 1'b0;
        end else begin
            done_irq <= finish;
            if (!enable) begin
                phase_q <= PH_IDLE;
            end else begin
                case (phase_q)
                    PH_IDLE:  if (start) phase_q <= PH_READ;
                    PH_READ: begin
                        if (bus_ack) begin
                            beat_q  <= bus_rdata;
                            phase_q <= PH_WRITE;
                        end
                    end
                    PH_WRITE: begin
                        if (bus_ack) begin
                            if (last && !rearm) phase_q <= PH_IDLE;
                            else                phase_q <= PH_READ;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign bus_req   = busy;
    assign bus_wr    = (phase_q == PH_WRITE);
    assign bus_addr  = bus_wr ? cur_dst : cur_src;
    assign bus_wdata = beat_q;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && enable) |=> bus_req && $stable(bus_addr) && $stable(bus_wr));
    assert_irq_follows_write_R6: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> $past(bus_req && bus_wr && bus_ack));
    assert_busy_fall_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done_irq || !$past(enable)));
    assert_start_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(kick && packet_ok(pkt)));
endmodule

// File: tb/sim_dma_blk_top.sv
module sim_dma_blk_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_req, bus_wr, busy, done_irq;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    always #5 clk = ~clk;

    dma_blk_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy), .done_irq(done_irq)
    );

    int    vecs = 0, fails = 0, cyc = 0, ack_mode = 0;
    int    n_writes = 0, n_irq = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] p_src = '0, p_dst = '0, m_src = '0, m_dst = '0;
    int          p_el = 0, p_fr = 0, m_el = 0, m_fr = 0, m_rld = 0;
    bit          p_rinc = 0, p_winc = 0, p_auto = 0, p_en = 0;
    bit          m_rinc = 0, m_winc = 0, m_run = 0, m_ph = 0, m_irq = 0;
    logic [63:0] m_data = '0;

    task automatic cmp(string tag, string sig, logic [63:0] act, logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, sig, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            p_src = '0; p_dst = '0; p_el = 0; p_fr = 0;
            p_rinc = 0; p_winc = 0; p_auto = 0; p_en = 0;
            m_run = 0; m_ph = 0; m_irq = 0; m_data = '0;
        end else begin
            bit irq_n;
            irq_n = 0;
            if (!p_en) begin
                m_run = 0;
            end else if (!m_run) begin
                if (cfg_we && cfg_addr == 3'd6 && p_el != 0 && p_fr != 0) begin
                    m_run = 1; m_ph = 0; m_src = p_src; m_dst = p_dst;
                    m_el = p_el; m_rld = p_el; m_fr = p_fr; m_rinc = p_rinc; m_winc = p_winc;
                end
            end else if (bus_ack) begin
                if (!m_ph) begin
                    m_data = {~m_src, m_src};
                    m_ph = 1;
                end else begin
                    bit fin;
                    fin = (m_el == 1 && m_fr == 1);
                    if (m_rinc) m_src = m_src + 32'd8;
                    if (m_winc) m_dst = m_dst + 32'd8;
                    if (m_el == 1) begin m_el = m_rld; m_fr = m_fr - 1; end
                    else m_el = m_el - 1;
                    m_ph = 0;
                    if (fin) begin
                        irq_n = 1;
                        if (p_auto && p_el != 0 && p_fr != 0) begin
                            m_src = p_src; m_dst = p_dst; m_el = p_el; m_rld = p_el;
                            m_fr = p_fr; m_rinc = p_rinc; m_winc = p_winc;
                        end else begin
                            m_run = 0;
                        end
                    end
                end
            end
            m_irq = irq_n;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: p_src = cfg_wdata;
                    3'd1: p_dst = cfg_wdata;
                    3'd2: p_el  = int'(cfg_wdata[15:0]);
                    3'd3: p_fr  = int'(cfg_wdata[12:0]);
                    3'd4: begin p_rinc = cfg_wdata[0]; p_winc = cfg_wdata[1]; p_auto = cfg_wdata[2]; end
                    3'd5: p_en = cfg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // compare on every clock, then drive the bus responder
    always @(negedge clk) begin
        cyc++;
        cmp(cur_req, "busy", {63'd0, busy}, {63'd0, m_run});
        cmp(cur_req, "bus_req", {63'd0, bus_req}, {63'd0, m_run});
        cmp(cur_req, "done_irq", {63'd0, done_irq}, {63'd0, m_irq});
        if (m_run) begin
            cmp(cur_req, "bus_wr", {63'd0, bus_wr}, {63'd0, m_ph});
            cmp(cur_req, "bus_addr", {32'd0, bus_addr}, {32'd0, m_ph ? m_dst : m_src});
            if (m_ph) cmp(cur_req, "bus_wdata", bus_wdata, m_data);
        end
        if (done_irq) n_irq++;
        case (ack_mode)
            0: bus_ack = bus_req;
            1: bus_ack = bus_req && (cyc % 3 == 0);
            default: bus_ack = bus_req && (cyc % 2 == 0);
        endcase
        bus_rdata = bus_ack ? {~bus_addr, bus_addr} : 64'd0;
        if (bus_ack && bus_wr) n_writes++;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d,
                         input int el, input int fr, input logic [31:0] mode);
        wr(3'd0, s); wr(3'd1, d); wr(3'd2, el); wr(3'd3, fr); wr(3'd4, mode);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int w0, i0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        cmp("R1", "reset busy", {63'd0, busy}, 64'd0);
        cmp("R1", "reset irq", {63'd0, done_irq}, 64'd0);

        // R2 R5 R6: 3 x 2 block, source increments, destination fixed
        cur_req = "R2/R5/R6 3x2 src-inc";
        wr(3'd5, 32'd1);
        setup(32'h1000, 32'h8000, 3, 2, 32'd1);
        w0 = n_writes; i0 = n_irq;
        wr(3'd6, 32'd0);
        wait_idle();
        cmp("R5", "writes 3x2", n_writes - w0, 64'd6);
        cmp("R6", "irq count", n_irq - i0, 64'd1);

        // R3 R4: both increment, slow acknowledge
        cur_req = "R3/R4 2x3 both-inc";
        ack_mode = 1;
        setup(32'h2000, 32'h9000, 2, 3, 32'd3);
        w0 = n_writes;
        wr(3'd6, 32'd0);
        wait_idle();
        cmp("R4", "writes 2x3", n_writes - w0, 64'd6);

        // R4: both fixed, single element
        cur_req = "R4 1x1 fixed";
        ack_mode = 2;
        setup(32'h3000, 32'hA000, 1, 1, 32'd0);
        wr(3'd6, 32'd0);
        wait_idle();

        // R8: zero counts ignored
        cur_req = "R8 zero count";
        ack_mode = 0;
        w0 = n_writes;
        setup(32'h3000, 32'hA000, 0, 2, 32'd1);
        wr(3'd6, 32'd0);
        repeat (3) @(negedge clk);
        cmp("R8", "busy el=0", {63'd0, busy}, 64'd0);
        setup(32'h3000, 32'hA000, 2, 0, 32'd1);
        wr(3'd6, 32'd0);
        repeat (3) @(negedge clk);
        cmp("R8", "busy fr=0", {63'd0, busy}, 64'd0);
        cmp("R8", "no writes", n_writes - w0, 64'd0);

        // R5: frame count keeps 13 bits (0x2002 -> 2)
        cur_req = "R5 frame truncation";
        setup(32'h4000, 32'hB000, 1, 32'h2002, 32'd1);
        w0 = n_writes;
        wr(3'd6, 32'd0);
        wait_idle();
        cmp("R5", "writes truncated", n_writes - w0, 64'd2);

        // R9: disabled trigger ignored, then halt mid-run
        cur_req = "R9 enable";
        wr(3'd5, 32'd0);
        setup(32'h5000, 32'hC000, 4, 2, 32'd1);
        wr(3'd6, 32'd0);
        repeat (2) @(negedge clk);
        cmp("R9", "busy disabled", {63'd0, busy}, 64'd0);
        wr(3'd5, 32'd1);
        i0 = n_irq;
        wr(3'd6, 32'd0);
        repeat (3) @(negedge clk);
        wr(3'd5, 32'd0);
        @(negedge clk);
        cmp("R9", "busy halted", {63'd0, busy}, 64'd0);
        cmp("R9", "no irq", n_irq - i0, 64'd0);
        wr(3'd5, 32'd1);

        // R10: second trigger while busy ignored
        cur_req = "R10 retrigger";
        setup(32'h6000, 32'hD000, 4, 1, 32'd1);
        w0 = n_writes;
        wr(3'd6, 32'd0);
        wr(3'd6, 32'd0);
        wait_idle();
        cmp("R10", "writes", n_writes - w0, 64'd4);

        // R7: re-arm runs blocks back to back
        cur_req = "R7 re-arm";
        setup(32'h7000, 32'hE000, 2, 1, 32'd5);
        i0 = n_irq;
        wr(3'd6, 32'd0);
        while (n_irq - i0 < 2) @(negedge clk);
        cmp("R7", "busy between blocks", {63'd0, busy}, 64'd1);
        wr(3'd5, 32'd0);
        @(negedge clk);
        cmp("R7", "irq count", n_irq - i0, 64'd2);
        cmp("R7", "halted", {63'd0, busy}, 64'd0);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule